// File: doc/BRIEF.md
# PCIe Endpoint Base Address Register Bank and Window Decoder

This block holds the base address registers of one PCIe endpoint function and decides, for every incoming request address, which of those registers claims it. Each register slot has a fixed aperture size, a fixed resource kind (memory or I/O) and a fixed prefetchable flag, all set by parameters. Configuration software can change only the bits above the aperture boundary. As a result, the usual sizing sequence works: write all ones, read the value back, then write the chosen base.

Request addresses taken from received headers arrive with a valid strobe and a memory/I/O flag. In the same cycle the block reports whether a programmed, enabled window contains the address. It also reports the slot index of that window and the offset of the address inside it. Memory windows respond only while the memory-enable input is high, and I/O windows only while the I/O-enable input is high.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every writable base bit is zero, so a slot reads back only its hardwired attribute bits, and `hit` is low while no request is valid.
- R2: Attribute encoding in the read value. For a memory slot, bit 0 = 0, bits 2:1 = 00 (32-bit addressing) and bit 3 = the prefetchable parameter. For an I/O slot, bit 0 = 1 and bit 1 = 0.
- R3: A slot of size 2^k has bits k-1 and below read-only. Apart from the attribute bits, those bits read as zero. After all ones are written, the read value is ones in bits 31..k plus the attribute bits, for example 0xFFFFF000 for a 4 KB memory slot.
- R4: A configuration write latches bits 31..k of the write data as the base and drops the lower bits of the write data.
- R5: A configuration read returns its data on `cfgRdData` with `cfgRdValid` high exactly one cycle after `cfgRdEn`. `cfgRdValid` is low in every other cycle.
- R6: When a request address satisfies base <= address < base + size for an enabled slot of the matching kind, `hit` is high in the same cycle as `reqValid`. `hitIndex` then gives the slot and `hitOffset` gives the address with bits 31..k cleared.
- R7: An address outside every window does not hit. With no hit, `hitIndex` and `hitOffset` are zero.
- R8: A slot whose size parameter is zero is disabled: it reads as zero and never hits. Slot numbers from `NUM_BARS` up to 5 also read as zero, and writes to them are ignored.
- R9: Memory requests (`reqIsIo` = 0) match only memory slots, and only while `memEnable` is high. I/O requests match only I/O slots, and only while `ioEnable` is high.
- R10: When windows overlap, the lowest slot index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgIndex | input | 3 | Register slot addressed by the configuration access (0 to 5) |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data, registered |
| cfgRdValid | output | 1 | Read data valid, one cycle after cfgRdEn |
| memEnable | input | 1 | Memory-space decode enable from the command register |
| ioEnable | input | 1 | I/O-space decode enable from the command register |
| reqValid | input | 1 | Request address valid |
| reqIsIo | input | 1 | Request is an I/O request (1) or a memory request (0) |
| reqAddr | input | 32 | Request address |
| hit | output | 1 | Address claimed by a slot |
| hitIndex | output | 2 | Index of the claiming slot |
| hitOffset | output | 32 | Address offset inside the claiming window |

## Verification
The hardest case to reach from the ports is two programmed windows that overlap. Because the windows are naturally aligned, this can happen only when a small window is placed inside a large one. The stimulus therefore first programs the 256 MB memory slot at 0x70000000 and puts the 4 KB slot inside it at 0x71000000. It then sends addresses that fall only in the large window, addresses in both windows, and the last byte of the large window, and it checks the claiming index for each. Cross-kind requests and enable-off cases are sent against the same programmed bases, so a miss can come only from the kind check or the enable gating.

// File: rtl/bar_pkg.sv
package bar_pkg;
  // Number of register slots in a Type 0 header
  localparam int unsigned MAX_SLOTS = 6;
  localparam int unsigned CFG_IDX_W = 3;

  typedef struct packed {
    logic [MAX_SLOTS-1:0] wrSel;   // one-hot write select
    logic [MAX_SLOTS-1:0] rdSel;   // one-hot read select
    logic                 rdLoad;  // capture read data this cycle
  } barStrobes_t;
endpackage

// File: rtl/bar_cfg_ctrl.sv
module bar_cfg_ctrl
  import bar_pkg::*;
#(
  parameter int unsigned NUM_BARS = 4
) (
  input  logic                 cfgWrEn,
  input  logic                 cfgRdEn,
  input  logic [CFG_IDX_W-1:0] cfgIndex,
  output barStrobes_t          strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdLoad = cfgRdEn;
    for (int i = 0; i < int'(MAX_SLOTS); i++) begin
      if (i < int'(NUM_BARS) && cfgIndex == CFG_IDX_W'(i)) begin
        strobes.wrSel[i] = cfgWrEn;
        strobes.rdSel[i] = cfgRdEn;
      end
    end
  end
endmodule

// File: rtl/bar_datapath.sv
module bar_datapath
  import bar_pkg::*;
#(
  parameter int unsigned NUM_BARS = 4,
  parameter int unsigned SIZE_LOG2 [NUM_BARS] = '{12, 28, 8, 0},
  parameter logic [NUM_BARS-1:0] IS_IO    = 4'b0100,
  parameter logic [NUM_BARS-1:0] PREFETCH = 4'b0010,
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  barStrobes_t      strobes,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  output logic             cfgRdValid,
  input  logic             memEnable,
  input  logic             ioEnable,
  input  logic             reqValid,
  input  logic             reqIsIo,
  input  logic [31:0]      reqAddr,
  output logic             hit,
  output logic [IDX_W-1:0] hitIndex,
  output logic [31:0]      hitOffset
);
  logic [31:0]         baseReg [NUM_BARS];
  logic [31:0]         maskArr [NUM_BARS];
  logic [31:0]         attrArr [NUM_BARS];
  logic [NUM_BARS-1:0] match;

  // Strobe bits for slots this configuration does not implement
  logic unusedStrobes;
  assign unusedStrobes = ^{strobes.wrSel, strobes.rdSel};

  for (genvar g = 0; g < NUM_BARS; g++) begin : gSlot
    localparam bit SLOT_ON = (SIZE_LOG2[g] != 0);
    localparam logic [31:0] SLOT_MASK =
      SLOT_ON ? ~((32'h1 << SIZE_LOG2[g]) - 32'h1) : 32'h0;
    localparam logic [31:0] SLOT_ATTR =
      !SLOT_ON ? 32'h0 :
      IS_IO[g] ? 32'h1 : {28'h0, PREFETCH[g], 3'b000};

    assign maskArr[g] = SLOT_MASK;
    assign attrArr[g] = SLOT_ATTR;

    always_ff @(posedge clk) begin
      if (!rstN)                 baseReg[g] <= '0;
      else if (strobes.wrSel[g]) baseReg[g] <= cfgWrData & SLOT_MASK;
    end

    logic spaceOk;
    assign spaceOk = IS_IO[g] ? (reqIsIo && ioEnable) : (!reqIsIo && memEnable);
    assign match[g] = SLOT_ON && reqValid && spaceOk &&
                      ((reqAddr & SLOT_MASK) == baseReg[g]);
  end

  // Configuration read path
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < int'(NUM_BARS); i++)
      if (strobes.rdSel[i]) rdMux |= baseReg[i] | attrArr[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdData  <= '0;
      cfgRdValid <= 1'b0;
    end else begin
      cfgRdData  <= strobes.rdLoad ? rdMux : 32'h0;
      cfgRdValid <= strobes.rdLoad;
    end
  end

  // Window claim: lowest index wins, so scan downwards
  always_comb begin
    hit       = 1'b0;
    hitIndex  = '0;
    hitOffset = '0;
    for (int i = int'(NUM_BARS) - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit       = 1'b1;
        hitIndex  = IDX_W'(i);
        hitOffset = reqAddr & ~maskArr[i];
      end
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_pkg::*;
#(
  parameter int unsigned NUM_BARS = 4,
  parameter int unsigned SIZE_LOG2 [NUM_BARS] = '{12, 28, 8, 0},
  parameter logic [NUM_BARS-1:0] IS_IO    = 4'b0100,
  parameter logic [NUM_BARS-1:0] PREFETCH = 4'b0010,
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic                 cfgRdEn,
  input  logic [CFG_IDX_W-1:0] cfgIndex,
  input  logic [31:0]          cfgWrData,
  output logic [31:0]          cfgRdData,
  output logic                 cfgRdValid,
  input  logic                 memEnable,
  input  logic                 ioEnable,
  input  logic                 reqValid,
  input  logic                 reqIsIo,
  input  logic [31:0]          reqAddr,
  output logic                 hit,
  output logic [IDX_W-1:0]     hitIndex,
  output logic [31:0]          hitOffset
);
  barStrobes_t strobes;

  bar_cfg_ctrl #(.NUM_BARS(NUM_BARS)) ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgRdEn (cfgRdEn),
    .cfgIndex(cfgIndex),
    .strobes (strobes)
  );

  bar_datapath #(
    .NUM_BARS (NUM_BARS),
    .SIZE_LOG2(SIZE_LOG2),
    .IS_IO    (IS_IO),
    .PREFETCH (PREFETCH)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .cfgRdValid(cfgRdValid),
    .memEnable (memEnable),
    .ioEnable  (ioEnable),
    .reqValid  (reqValid),
    .reqIsIo   (reqIsIo),
    .reqAddr   (reqAddr),
    .hit       (hit),
    .hitIndex  (hitIndex),
    .hitOffset (hitOffset)
  );
endmodule

// File: rtl/bar_window_checker.sv
module bar_window_checker #(
  parameter int unsigned NUM_BARS = 4,
  parameter int unsigned SIZE_LOG2 [NUM_BARS] = '{12, 28, 8, 0},
  parameter logic [NUM_BARS-1:0] IS_IO = 4'b0100,
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgRdEn,
  input logic             cfgRdValid,
  input logic             memEnable,
  input logic             ioEnable,
  input logic             reqValid,
  input logic             reqIsIo,
  input logic             hit,
  input logic [IDX_W-1:0] hitIndex,
  input logic [31:0]      hitOffset
);
  function automatic logic [31:0] lowBits(int unsigned idx);
    return (SIZE_LOG2[idx] == 0) ? 32'h0 : ((32'h1 << SIZE_LOG2[idx]) - 32'h1);
  endfunction

  assert_read_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> cfgRdValid);
  assert_read_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> !cfgRdValid);
  assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> reqValid);
  assert_offset_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((hitOffset & ~lowBits(int'(hitIndex))) == 32'h0));
  assert_no_hit_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (SIZE_LOG2[hitIndex] != 0));
  assert_mem_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !reqIsIo) |-> (memEnable && !IS_IO[hitIndex]));
  assert_io_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hit && reqIsIo) |-> (ioEnable && IS_IO[hitIndex]));
  assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitIndex == '0 && hitOffset == 32'h0));
endmodule

bind bar_window_decoder bar_window_checker #(
  .NUM_BARS (NUM_BARS),
  .SIZE_LOG2(SIZE_LOG2),
  .IS_IO    (IS_IO)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgRdEn   (cfgRdEn),
  .cfgRdValid(cfgRdValid),
  .memEnable (memEnable),
  .ioEnable  (ioEnable),
  .reqValid  (reqValid),
  .reqIsIo   (reqIsIo),
  .hit       (hit),
  .hitIndex  (hitIndex),
  .hitOffset (hitOffset)
);

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [2:0]  cfgIndex = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        memEnable = 1'b0, ioEnable = 1'b0;
  logic        reqValid = 1'b0, reqIsIo = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        hit;
  logic [1:0]  hitIndex;
  logic [31:0] hitOffset;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } rdExp_t;
  rdExp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_window_decoder uut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgIndex(cfgIndex),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .memEnable(memEnable), .ioEnable(ioEnable),
    .reqValid(reqValid), .reqIsIo(reqIsIo), .reqAddr(reqAddr),
    .hit(hit), .hitIndex(hitIndex), .hitOffset(hitOffset)
  );

  // Monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rstN && cfgRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected read data actual=%08h expected=none", cfgRdData);
      end else begin
        rdExp_t e;
        e = expQ.pop_front();
        if (cfgRdData !== e.data) begin
          fails++;
          $display("FAIL %s read actual=%08h expected=%08h", e.tag, cfgRdData, e.data);
        end
      end
    end
  end

  task automatic cfgWrite(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIndex = idx; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Driver: issue the read and push the expected item
  task automatic cfgRead(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    rdExp_t e;
    @(negedge clk);
    e.data = exp; e.tag = tag;
    expQ.push_back(e);
    cfgRdEn = 1'b1; cfgIndex = idx;
    @(negedge clk);
    cfgRdEn = 1'b0;
  endtask

  task automatic decode(input logic io, input logic [31:0] a, input logic expHit,
                        input logic [1:0] expIdx, input logic [31:0] expOff, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = io; reqAddr = a;
    #1;
    checks++;
    if (hit !== expHit || hitIndex !== expIdx || hitOffset !== expOff) begin
      fails++;
      $display("FAIL %s addr=%08h actual hit=%0b idx=%0d off=%08h expected hit=%0b idx=%0d off=%08h",
               tag, a, hit, hitIndex, hitOffset, expHit, expIdx, expOff);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state, R2 attribute bits
    checks++;
    if (hit !== 1'b0 || cfgRdValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual hit=%0b rdValid=%0b expected 0 0", hit, cfgRdValid);
    end
    cfgRead(0, 32'h0000_0000, "R1 slot0 after reset");
    cfgRead(1, 32'h0000_0008, "R2 prefetch memory attr");
    cfgRead(2, 32'h0000_0001, "R2 io attr");
    cfgRead(3, 32'h0000_0000, "R8 disabled slot after reset");

    // R3 sizing
    for (int i = 0; i < 6; i++) cfgWrite(3'(i), 32'hFFFF_FFFF);
    cfgRead(0, 32'hFFFF_F000, "R3 size 4KB");
    cfgRead(1, 32'hF000_0008, "R3 size 256MB prefetch");
    cfgRead(2, 32'hFFFF_FF01, "R3 size io 256B");
    cfgRead(3, 32'h0000_0000, "R8 disabled slot sizing");
    cfgRead(5, 32'h0000_0000, "R8 unimplemented slot");

    // R4 base programming
    cfgWrite(0, 32'h7100_0ABC);
    cfgWrite(1, 32'h7000_0000);
    cfgWrite(2, 32'h0000_C0FF);
    cfgWrite(3, 32'h1234_5678);
    cfgRead(0, 32'h7100_0000, "R4 base latch slot0");
    cfgRead(1, 32'h7000_0008, "R4 base latch slot1");
    cfgRead(2, 32'h0000_C001, "R4 base latch io slot");
    cfgRead(3, 32'h0000_0000, "R8 disabled slot after write");

    // R5 back-to-back reads
    @(negedge clk);
    expQ.push_back('{32'h7100_0000, "R5 b2b first"});
    cfgRdEn = 1'b1; cfgIndex = 3'd0;
    @(negedge clk);
    expQ.push_back('{32'h0000_C001, "R5 b2b second"});
    cfgIndex = 3'd2;
    @(negedge clk);
    cfgRdEn = 1'b0;
    @(negedge clk);

    // R9 enables low: nothing hits
    decode(1'b0, 32'h7100_1000, 1'b0, 2'd0, 32'h0, "R9 memEnable low");
    decode(1'b1, 32'h0000_C0FF, 1'b0, 2'd0, 32'h0, "R9 ioEnable low");
    memEnable = 1'b1; ioEnable = 1'b1;

    // R6 hits, R10 priority, R7 misses
    decode(1'b0, 32'h7100_1000, 1'b1, 2'd1, 32'h0100_1000, "R6 hit large window");
    decode(1'b0, 32'h7FFF_FFFF, 1'b1, 2'd1, 32'h0FFF_FFFF, "R6 last byte of window");
    decode(1'b0, 32'h7000_0000, 1'b1, 2'd1, 32'h0000_0000, "R6 first byte of window");
    decode(1'b0, 32'h7100_0123, 1'b1, 2'd0, 32'h0000_0123, "R10 overlap lowest index");
    decode(1'b0, 32'h8000_0000, 1'b0, 2'd0, 32'h0, "R7 just above window");
    decode(1'b0, 32'h6FFF_FFFF, 1'b0, 2'd0, 32'h0, "R7 just below window");
    decode(1'b1, 32'h0000_C0FF, 1'b1, 2'd2, 32'h0000_00FF, "R6 io hit");
    decode(1'b1, 32'h0000_C100, 1'b0, 2'd0, 32'h0, "R7 io miss");
    decode(1'b1, 32'h7100_1000, 1'b0, 2'd0, 32'h0, "R9 io request vs memory slot");
    decode(1'b0, 32'h0000_C010, 1'b0, 2'd0, 32'h0, "R9 memory request vs io slot");
    decode(1'b0, 32'h0000_0010, 1'b0, 2'd0, 32'h0, "R8 disabled slot no hit");

    // R6 no valid, no hit
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'h7100_1000; reqIsIo = 1'b0;
    #1;
    checks++;
    if (hit !== 1'b0) begin
      fails++;
      $display("FAIL R6 hit without valid actual=%0b expected=0", hit);
    end

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R5 missing read data actual=%0d expected=0", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule